// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Compare and PWM Output

This block is a general-purpose up-counting timer for a large chip. Software sets it up through a small register file: a control word, a directly writable counter, a reload value, a compare value, a write-only reload strobe, a sticky status word and two mask words. The counter advances on the functional clock, either on every cycle or on the output of a power-of-two prescaler. When it passes its all-ones value it either wraps to zero or reloads from the reload register.

Two events are produced. One is the overflow at the wrap. The other is a compare hit, raised on the step that brings the counter to the compare value. Each event sets a sticky status bit. The status bits are masked onto an interrupt line and a wake line. The same events can also drive a single waveform output. That output either pulses for one clock or toggles, starting from a programmable idle level.

Register addresses on the 3-bit `addr` bus are: 0 control, 1 counter, 2 reload value, 3 reload strobe, 4 compare value, 5 status, 6 interrupt mask, 7 wake mask. Writes take effect at the rising clock edge where `wr_en` is high. `rd_data` is a combinational view of the register that `addr` selects. The strobe address reads as zero, and so do the undefined control bits.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 (control at address 0, counter at 1, reload at 2, compare at 4, status at 5), and `pwm_o`, `irq_o` and `wake_o` are low.
- R2: Control bit 0 runs the counter. With it clear, the counter holds its value. With it set and no divider, the counter adds one on each clock, starting from the edge that follows the control write.
- R3: Control bit 5 enables the divider and bits 4:2 hold a code n. With the divider on, the counter advances once every 2^(n+1) clocks, so N clocks after the starting control write it has advanced floor(N / 2^(n+1)). With bit 5 clear, the code has no effect.
- R4: On a step taken from all-ones with control bit 1 clear, the counter becomes 0 and keeps counting, and status bit 1 (overflow) is set.
- R5: With control bit 1 set, a step from all-ones loads the reload register (address 2) into the counter instead of 0, and it still sets status bit 1.
- R6: A write to address 3, whatever its data, copies the reload register into the counter. A write to address 1 sets the counter to the written data. Either write takes priority over a step in the same cycle.
- R7: With control bit 6 set, a step that makes the counter equal to the compare register (address 4) sets status bit 0 at that same edge. With bit 6 clear, passing the compare value sets nothing.
- R8: The status bits are sticky. Writing 1 to a bit at address 5 clears it, writing 0 leaves it unchanged, and an event in the same cycle as a clear leaves the bit set.
- R9: `irq_o` is high when any status bit is set whose bit is also set in the interrupt mask (address 6). `wake_o` does the same with the wake mask (address 7).
- R10: Control bit 7 is the idle level of `pwm_o`. Bits 11:10 choose which events act on the output: 0 none, 1 overflow only, 2 or 3 overflow and compare hit.
- R11: With control bit 12 clear (pulse), each chosen event drives `pwm_o` to the opposite of the idle level for exactly the one clock after the event's edge.
- R12: With control bit 12 set (toggle), each chosen event inverts `pwm_o`. Any control write returns `pwm_o` to the idle level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | W (32) | Write data |
| rd_data | output | W (32) | Combinational read data of the addressed register |
| irq_o | output | 1 | Status masked by interrupt mask |
| wake_o | output | 1 | Status masked by wake mask |
| pwm_o | output | 1 | Pulse or toggle waveform output |

## Verification
Every counter and status result appears at the edge that follows the cause. A register write is visible after its own edge. A step, wrap or reload is visible one edge after it is due, and with a divider code n the k-th step comes 2^(n+1)·k edges after the starting control write. A status bit is set at the same edge as the counter step that raises it, and the mask outputs follow with no further register. A pulse shows on `pwm_o` for the one clock after the event's edge. The bench drives inputs and samples at the falling edge, and it counts the exact number of rising edges between the last write and each read.

// File: rtl/rtim_pkg.sv
// Shared definitions for the reload timer: register addresses, control word
// layout and status bit positions. Assumes a 3-bit register address bus.
package rtim_pkg;
    localparam int CODE_W     = 3;   // width of the divider code
    localparam int NSTAT      = 2;   // number of sticky status bits
    localparam int STAT_MATCH = 0;
    localparam int STAT_OVF   = 1;

    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_COUNT  = 3'd1,
        RA_LOAD   = 3'd2,
        RA_TRIG   = 3'd3,
        RA_MATCH  = 3'd4,
        RA_STAT   = 3'd5,
        RA_IRQEN  = 3'd6,
        RA_WAKEEN = 3'd7
    } reg_addr_e;

    // Control word, MSB first: bit 12 down to bit 0
    typedef struct packed {
        logic              toggle;    // 12
        logic [1:0]        trg_sel;   // 11:10
        logic [1:0]        spare;     // 9:8, always stored as 0
        logic              def_lvl;   // 7
        logic              cmp_en;    // 6
        logic              pre_en;    // 5
        logic [CODE_W-1:0] pre_code;  // 4:2
        logic              auto_rl;   // 1
        logic              start;     // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [CTRL_W-1:0] CTRL_MASK = 13'h1CFF;
endpackage

// File: rtl/rtim_prescaler.sv
// Divider in front of the counter. Emits a one-cycle tick every 2^(code+1)
// clocks while running with the divider on, or on every clock with it off.
// Assumes the code is stable while running, or that a change restarts the
// phase: the divider state is compared with >= so a smaller code never stalls.
module rtim_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              pre_en,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DIV_W = 1 << CODE_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W:0]   span_m1;
    logic             hit;

    // Divide ratio 2^(code+1) as a one-hot value, and its terminal count
    always_comb begin
        span = '0;
        span[{1'b0, code} + 1'b1] = 1'b1;
        span_m1 = span - 1'b1;
        hit = (div_q >= span_m1[DIV_W-1:0]);
        tick = run & (~pre_en | hit);
    end

    // Divider phase: cleared while idle, disabled, or on the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !pre_en || hit) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/rtim_counter.sv
// Up counter with wrap or reload at all-ones. Software writes (direct value
// or reload strobe) override a step in the same cycle. Exposes the value the
// next step would produce, so the compare logic can look ahead.
module rtim_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         auto_rl,
    input  logic         cnt_wr,
    input  logic         trig_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] nxt_o,
    output logic         adv_o,
    output logic         ovf_o
);
    logic [W-1:0] cnt_q;

    // Next step value and the events a step produces
    always_comb begin
        nxt_o = (cnt_q == '1) ? (auto_rl ? load_val : '0) : cnt_q + 1'b1;
        adv_o = tick & ~cnt_wr & ~trig_wr;
        ovf_o = adv_o & (cnt_q == '1);
    end

    // Counter register: direct write, then reload strobe, then step
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= wr_val;
        else if (trig_wr) cnt_q <= load_val;
        else if (tick)    cnt_q <= nxt_o;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rtim_status.sv
// Sticky event bits, cleared by writing one. An event arriving in the same
// cycle as a clear wins, so no event is lost.
module rtim_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] stat_o
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic bit_q;
        // One sticky flag: set by its event, cleared by a write of one
        always_ff @(posedge clk) begin
            if (!rst_n)                       bit_q <= 1'b0;
            else if (set_i[b])                bit_q <= 1'b1;
            else if (clr_wr && clr_mask[b])   bit_q <= 1'b0;
        end
        assign stat_o[b] = bit_q;
    end
endmodule

// File: rtl/rtim_pwm.sv
// Waveform output. The selected events either pulse the output away from
// its idle level for one clock or invert it. A control write restarts the
// output at the idle level.
module rtim_pwm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_i,
    input  logic       mat_i,
    input  logic [1:0] trg_sel,
    input  logic       toggle,
    input  logic       def_lvl,
    input  logic       ctrl_wr,
    output logic       pwm_o
);
    logic sel;
    logic st_q;

    // Event selection: overflow for codes 1..3, compare hit for codes 2..3
    assign sel = ((trg_sel != 2'd0) & ovf_i) | (trg_sel[1] & mat_i);

    // Deviation-from-idle state: pulse follows the event, toggle flips on it
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr) st_q <= 1'b0;
        else if (toggle)       st_q <= st_q ^ sel;
        else                   st_q <= sel;
    end

    assign pwm_o = def_lvl ^ st_q;
endmodule

// File: rtl/reload_timer.sv
// Register-mapped auto-reload timer. Holds the register file, decodes
// writes, muxes reads and wires the divider, counter, status and output
// blocks. Assumes W is at least the control word width.
module reload_timer
    import rtim_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         irq_o,
    output logic         wake_o,
    output logic         pwm_o
);
    ctrl_t            ctrl_q;
    logic [W-1:0]     load_q;
    logic [W-1:0]     match_q;
    logic [NSTAT-1:0] irq_en_q;
    logic [NSTAT-1:0] wake_en_q;
    logic [NSTAT-1:0] stat_q;
    logic [NSTAT-1:0] stat_set;
    logic [W-1:0]     cnt_q;
    logic [W-1:0]     nxt_val;
    logic             ctrl_wr, cnt_wr, trig_wr, stat_wr;
    logic             tick, adv, ovf_evt, mat_evt;

    // Write strobes for registers owned by sub-blocks
    always_comb begin
        ctrl_wr = wr_en && (reg_addr_e'(addr) == RA_CTRL);
        cnt_wr  = wr_en && (reg_addr_e'(addr) == RA_COUNT);
        trig_wr = wr_en && (reg_addr_e'(addr) == RA_TRIG);
        stat_wr = wr_en && (reg_addr_e'(addr) == RA_STAT);
    end

    // Configuration registers held at this level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            load_q    <= '0;
            match_q   <= '0;
            irq_en_q  <= '0;
            wake_en_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_CTRL:   ctrl_q    <= ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_MASK);
                RA_LOAD:   load_q    <= wr_data;
                RA_MATCH:  match_q   <= wr_data;
                RA_IRQEN:  irq_en_q  <= wr_data[NSTAT-1:0];
                RA_WAKEEN: wake_en_q <= wr_data[NSTAT-1:0];
                default:   ;
            endcase
        end
    end

    rtim_prescaler #(.CODE_W(CODE_W)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q.start),
        .pre_en (ctrl_q.pre_en),
        .code   (ctrl_q.pre_code),
        .tick   (tick)
    );

    rtim_counter #(.W(W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .auto_rl  (ctrl_q.auto_rl),
        .cnt_wr   (cnt_wr),
        .trig_wr  (trig_wr),
        .wr_val   (wr_data),
        .load_val (load_q),
        .cnt_o    (cnt_q),
        .nxt_o    (nxt_val),
        .adv_o    (adv),
        .ovf_o    (ovf_evt)
    );

    // Compare hit: a step that lands on the compare value
    assign mat_evt = ctrl_q.cmp_en & adv & (nxt_val == match_q);

    // Map events onto their status bit positions
    always_comb begin
        stat_set             = '0;
        stat_set[STAT_OVF]   = ovf_evt;
        stat_set[STAT_MATCH] = mat_evt;
    end

    rtim_status #(.N(NSTAT)) i_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (stat_set),
        .clr_wr   (stat_wr),
        .clr_mask (wr_data[NSTAT-1:0]),
        .stat_o   (stat_q)
    );

    rtim_pwm i_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_i   (ovf_evt),
        .mat_i   (mat_evt),
        .trg_sel (ctrl_q.trg_sel),
        .toggle  (ctrl_q.toggle),
        .def_lvl (ctrl_q.def_lvl),
        .ctrl_wr (ctrl_wr),
        .pwm_o   (pwm_o)
    );

    // Masked event lines
    assign irq_o  = |(stat_q & irq_en_q);
    assign wake_o = |(stat_q & wake_en_q);

    // Read mux
    always_comb begin
        case (reg_addr_e'(addr))
            RA_CTRL:   rd_data = W'(ctrl_q);
            RA_COUNT:  rd_data = cnt_q;
            RA_LOAD:   rd_data = load_q;
            RA_MATCH:  rd_data = match_q;
            RA_STAT:   rd_data = W'(stat_q);
            RA_IRQEN:  rd_data = W'(irq_en_q);
            RA_WAKEEN: rd_data = W'(wake_en_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rtim_checker.sv
// Property checker for the reload timer, attached with bind. Observes the
// control fields, the internal step and event strobes and the outputs.
module rtim_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         pre_en,
    input logic         auto_rl,
    input logic         toggle,
    input logic         def_lvl,
    input logic         tick,
    input logic         ctrl_wr,
    input logic         cnt_wr,
    input logic         trig_wr,
    input logic         stat_wr,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] load_q,
    input logic [1:0]   stat_q,
    input logic         ovf_evt,
    input logic         mat_evt,
    input logic         irq_o,
    input logic         pwm_o
);
    // R2: a stopped counter with no write holds its value
    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !cnt_wr && !trig_wr) |=> $stable(cnt_q));

    // R2: an ordinary step adds exactly one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '1 && !cnt_wr && !trig_wr) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    // R3: with the divider on, two steps are never on adjacent clocks
    a_r3_no_adjacent_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && tick && !ctrl_wr) |=> !tick);

    // R4: wrap without reload lands on zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '1 && !auto_rl && !cnt_wr && !trig_wr) |=> cnt_q == '0);

    // R5: wrap with reload lands on the reload value
    a_r5_reload_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == '1 && auto_rl && !cnt_wr && !trig_wr) |=> cnt_q == $past(load_q));

    // R8: events always land in status, even against a clear
    a_r8_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> stat_q[1]);
    a_r8_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        mat_evt |=> stat_q[0]);

    // R8: a set bit stays set without a status write
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !stat_wr) |=> stat_q[1]);

    // R9: the interrupt never rises with an empty status word
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (stat_q != 2'b00));

    // R11: a pulse away from idle lasts one clock when no new event comes
    a_r11_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle && pwm_o != def_lvl && !ctrl_wr && !ovf_evt && !mat_evt) |=> pwm_o == def_lvl);
endmodule

bind reload_timer rtim_checker #(.W(W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (ctrl_q.start),
    .pre_en  (ctrl_q.pre_en),
    .auto_rl (ctrl_q.auto_rl),
    .toggle  (ctrl_q.toggle),
    .def_lvl (ctrl_q.def_lvl),
    .tick    (tick),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .trig_wr (trig_wr),
    .stat_wr (stat_wr),
    .cnt_q   (cnt_q),
    .load_q  (load_q),
    .stat_q  (stat_q),
    .ovf_evt (ovf_evt),
    .mat_evt (mat_evt),
    .irq_o   (irq_o),
    .pwm_o   (pwm_o)
);

// File: tb/test_reload_timer.sv
// Self-checking bench: a vector table for divider and wrap timing, then
// directed tests for reset, reload, compare, status, masks and output.
module test_reload_timer;
    localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_LOAD = 3'd2, A_TRIG = 3'd3,
                           A_MATCH = 3'd4, A_STAT = 3'd5, A_IRQ = 3'd6, A_WAKE = 3'd7;
    localparam logic [31:0] C_RUN = 32'h1, C_AR = 32'h2, C_PRE = 32'h20, C_CMP = 32'h40,
                            C_DEF = 32'h80, C_TOG = 32'h1000;

    // {initial count, divider enable, code, clocks, expected count}
    localparam int NV = 8;
    localparam logic [83:0] VEC [NV] = '{
        {32'h0000_0000, 1'b0, 3'd0, 16'd10,  32'd10},
        {32'h0000_0000, 1'b1, 3'd0, 16'd10,  32'd5},
        {32'h0000_0000, 1'b1, 3'd1, 16'd10,  32'd2},
        {32'h0000_0000, 1'b1, 3'd2, 16'd17,  32'd2},
        {32'h0000_0000, 1'b1, 3'd7, 16'd600, 32'd2},
        {32'h0000_0000, 1'b0, 3'd5, 16'd3,   32'd3},
        {32'h0000_03E8, 1'b1, 3'd0, 16'd7,   32'd1003},
        {32'hFFFF_FFFE, 1'b0, 3'd0, 16'd5,   32'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, wake_o, pwm_o;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    reload_timer #(.W(32)) i_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_o(irq_o), .wake_o(wake_o), .pwm_o(pwm_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // One write: taken at the rising edge between two falling edges
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Combinational read, consumes no clock edge
    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, v);  check("R1 control", v, 32'h0);
        rd(A_CNT, v);   check("R1 counter", v, 32'h0);
        rd(A_LOAD, v);  check("R1 reload", v, 32'h0);
        rd(A_MATCH, v); check("R1 compare", v, 32'h0);
        rd(A_STAT, v);  check("R1 status", v, 32'h0);
        check("R1 outputs", {29'b0, pwm_o, irq_o, wake_o}, 32'h0);

        // R2 R3 R4: divider and wrap table
        for (int i = 0; i < NV; i++) begin
            logic [83:0] e;
            e = VEC[i];
            wr(A_CTRL, 32'h0);
            wr(A_CNT, e[83:52]);
            wr(A_CTRL, C_RUN | ({31'b0, e[51]} << 5) | ({29'b0, e[50:48]} << 2));
            wait_edges(int'(e[47:32]));
            rd(A_CNT, v);
            check($sformatf("R3 R2 vector %0d count", i), v, e[31:0]);
        end
        // R4: the last vector wrapped, so overflow is set
        rd(A_STAT, v); check("R4 overflow bit after wrap", v & 32'h2, 32'h2);

        // R2: stopped counter holds
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h77);
        wait_edges(5);
        rd(A_CNT, v); check("R2 stopped holds", v, 32'h77);

        // R5: reload on wrap
        wr(A_STAT, 32'h3);
        wr(A_LOAD, 32'h100);
        wr(A_CNT, 32'hFFFF_FFFD);
        wr(A_CTRL, C_RUN | C_AR);
        wait_edges(4);
        rd(A_CNT, v);  check("R5 reload then step", v, 32'h101);
        rd(A_STAT, v); check("R5 overflow status", v, 32'h2);

        // R9: masks
        check("R9 irq masked off", {31'b0, irq_o}, 32'h0);
        wr(A_IRQ, 32'h2);
        check("R9 irq on overflow", {31'b0, irq_o}, 32'h1);
        wr(A_WAKE, 32'h1);
        check("R9 wake mask other bit", {31'b0, wake_o}, 32'h0);
        wr(A_WAKE, 32'h2);
        check("R9 wake on overflow", {31'b0, wake_o}, 32'h1);

        // R8: write zero ignored, write one clears
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R8 zero write ignored", v, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); check("R8 one write clears", v, 32'h0);
        check("R9 irq drops after clear", {31'b0, irq_o}, 32'h0);

        // R6: reload strobe with arbitrary data
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'h55);
        wr(A_TRIG, 32'hDEAD);
        rd(A_CNT, v); check("R6 strobe loads reload", v, 32'h55);

        // R7: compare hit at the landing edge
        wr(A_STAT, 32'h3);
        wr(A_CNT, 32'h10);
        wr(A_MATCH, 32'h13);
        wr(A_CTRL, C_RUN | C_CMP);
        wait_edges(2);
        rd(A_STAT, v); check("R7 no hit before value", v, 32'h0);
        wait_edges(1);
        rd(A_STAT, v); check("R7 hit at value", v, 32'h1);

        // R7: compare disabled
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h3);
        wr(A_CNT, 32'h10);
        wr(A_CTRL, C_RUN);
        wait_edges(5);
        rd(A_STAT, v); check("R7 disabled no hit", v, 32'h0);

        // R10: idle level
        wr(A_CTRL, C_DEF);
        check("R10 idle level high", {31'b0, pwm_o}, 32'h1);

        // R11: pulse on overflow
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, C_RUN | (32'h1 << 10));
        wait_edges(1);
        check("R11 before pulse", {31'b0, pwm_o}, 32'h0);
        wait_edges(1);
        check("R11 pulse high", {31'b0, pwm_o}, 32'h1);
        wait_edges(1);
        check("R11 pulse one clock", {31'b0, pwm_o}, 32'h0);

        // R12: toggle on compare hit from high idle level
        wr(A_CTRL, 32'h0);
        wr(A_CNT, 32'h3);
        wr(A_MATCH, 32'h5);
        wr(A_CTRL, C_RUN | C_TOG | C_DEF | C_CMP | (32'h2 << 10));
        wait_edges(1);
        check("R12 idle before hit", {31'b0, pwm_o}, 32'h1);
        wait_edges(1);
        check("R12 toggled at hit", {31'b0, pwm_o}, 32'h0);
        wait_edges(1);
        check("R12 stays toggled", {31'b0, pwm_o}, 32'h0);
        wr(A_CTRL, C_DEF);
        check("R12 control write restores idle", {31'b0, pwm_o}, 32'h1);

        // R10: overflow-only select ignores compare hits
        wr(A_STAT, 32'h3);
        wr(A_CNT, 32'h3);
        wr(A_CTRL, C_RUN | C_TOG | C_CMP | (32'h1 << 10));
        wait_edges(3);
        check("R10 hit ignored by select 1", {31'b0, pwm_o}, 32'h0);
        rd(A_STAT, v); check("R10 hit did occur", v, 32'h1);

        // R10: select 0 ignores overflow
        wr(A_CTRL, 32'h0);
        wr(A_STAT, 32'h3);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, C_RUN | C_TOG);
        wait_edges(3);
        check("R10 select 0 no effect", {31'b0, pwm_o}, 32'h0);
        rd(A_STAT, v); check("R10 overflow did occur", v, 32'h2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule